// File: doc/BRIEF.md
# Start-Stop Serial Receiver with Error-Tagged FIFO

This block recovers characters from an asynchronous start-stop serial line. An enable pulse at sixteen times the bit rate paces all sampling. A falling edge on the line starts a candidate character, which is kept only if the line is still low at the centre of the start bit. Each later bit is sampled at the centre of its own period. The character format can be set at run time: 7 or 8 data bits sent least significant bit first, no parity or even or odd parity, and one or two stop bits.

Every completed character goes into a 16-entry receive queue. Each entry holds the data byte with its own parity-error and framing-error flags. The reader sees the oldest entry on the read outputs and removes it with a one-cycle pop. The fill level is always visible.

Two sticky indications cover line-level problems. Overrun is set when a character completes while the queue is full. Break is set when a framing error is followed by at least one whole frame time of low line. Both stay set until the clear input is pulsed.

Top module: `async_rx_core`

## Requirements
- R1: After reset the level is 0 and the overrun and break flags are 0.
- R2: A falling edge is accepted as a start bit only if the line is still low 8 sample ticks later. A shorter low pulse produces no character, and a following valid character is received normally.
- R3: Data bits arrive least significant bit first. With cfg_len8=1, eight bits are received. With cfg_len8=0, seven bits are received and rd_data[7] reads 0.
- R4: With cfg_par_en=1 the bit after the data is parity. rd_perr is 1 when the number of ones in the data and parity bits together is odd while cfg_par_odd=0, or even while cfg_par_odd=1. With cfg_par_en=0, rd_perr is 0.
- R5: rd_ferr is 1 when the first stop bit is sampled low. With cfg_stop2=1, the second stop bit is not checked.
- R6: The queue holds up to 16 characters in arrival order. level gives the count. rd_data, rd_perr and rd_ferr show the oldest entry, and a pop removes it.
- R7: If a character completes while level is 16, overrun is set, the character is dropped and the stored entries are unchanged.
- R8: After a framing error, if the line stays low for a whole frame time (start, data, parity and stop bits, in ticks), break is set. No further character is stored until the line returns high.
- R9: overrun and break stay set until clr_flags is pulsed, which clears both.
- R10: A pop while level is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick | input | 1 | Sample enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_stop2 | input | 1 | Two stop bits |
| pop | input | 1 | Remove the oldest queue entry |
| clr_flags | input | 1 | Clear overrun and break |
| rd_data | output | 8 | Oldest entry data |
| rd_perr | output | 1 | Oldest entry parity error |
| rd_ferr | output | 1 | Oldest entry framing error |
| level | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky overrun |
| break_det | output | 1 | Sticky break |

## Verification
The hardest case to reach is overrun. Seventeen complete frames must arrive with no pop in between, and the order of the kept entries must then be shown to be intact. The bench streams seventeen distinct bytes back to back and checks the overrun flag and the level. It then drains the queue and compares each byte with the first sixteen sent. Break is reached by holding the line low through a frame whose stop bit is low and then for more than a frame time. A contrasting case releases the line early, and break must stay clear.

// File: rtl/async_rx_core.sv
module async_rx_core #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_tick,
  input  logic                         rxd,
  input  logic                         cfg_len8,
  input  logic                         cfg_par_en,
  input  logic                         cfg_par_odd,
  input  logic                         cfg_stop2,
  input  logic                         pop,
  input  logic                         clr_flags,
  output logic [7:0]                   rd_data,
  output logic                         rd_perr,
  output logic                         rd_ferr,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         overrun,
  output logic                         break_det
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(OSR);
  localparam int FW = $clog2(12 * OSR + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_LOW} st_t;

  st_t           st;
  logic          rx_s1, rx, rx_last, pbit;
  logic [CW-1:0] phase;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic [FW-1:0] lowcnt;

  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  wire           at_mid   = phase == CW'(OSR / 2 - 1);
  wire           at_end   = phase == CW'(OSR - 1);
  wire [2:0]     last_bit = cfg_len8 ? 3'd7 : 3'd6;
  wire [7:0]     char_data = cfg_len8 ? shreg : {1'b0, shreg[7:1]};
  wire [FW-1:0]  frame_ticks = FW'((1 + (cfg_len8 ? 8 : 7) + (cfg_par_en ? 1 : 0)
                                    + (cfg_stop2 ? 2 : 1)) * OSR);
  wire           push     = smp_tick && st == S_STOP1 && at_end;
  wire           perr_c   = cfg_par_en && ((^char_data ^ pbit) != cfg_par_odd);
  wire           full     = level == LW'(DEPTH);
  wire           wr_ok    = push && !full;
  wire           rd_ok    = pop && level != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx    <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx    <= rx_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rx_last <= 1'b1;
      phase   <= '0;
      bitn    <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      lowcnt  <= '0;
    end else if (smp_tick) begin
      rx_last <= rx;
      phase   <= phase + 1'b1;
      case (st)
        S_IDLE: begin
          phase <= '0;
          if (rx_last && !rx) st <= S_START;
        end
        S_START: if (at_mid) begin
          phase <= '0;
          bitn  <= '0;
          st    <= rx ? S_IDLE : S_DATA;
        end
        S_DATA: if (at_end) begin
          shreg <= {rx, shreg[7:1]};
          bitn  <= bitn + 1'b1;
          if (bitn == last_bit) st <= cfg_par_en ? S_PAR : S_STOP1;
        end
        S_PAR: if (at_end) begin
          pbit <= rx;
          st   <= S_STOP1;
        end
        S_STOP1: if (at_end) begin
          lowcnt <= '0;
          if (!rx)            st <= S_LOW;
          else if (cfg_stop2) st <= S_STOP2;
          else                st <= S_IDLE;
        end
        S_STOP2: if (at_end) st <= S_IDLE;
        S_LOW: begin
          if (rx) st <= S_IDLE;
          else if (lowcnt != frame_ticks) lowcnt <= lowcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= {perr_c, !rx, char_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      level <= level + LW'(wr_ok) - LW'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun   <= 1'b0;
      break_det <= 1'b0;
    end else if (clr_flags) begin
      overrun   <= 1'b0;
      break_det <= 1'b0;
    end else begin
      if (push && full) overrun <= 1'b1;
      if (st == S_LOW && lowcnt == frame_ticks) break_det <= 1'b1;
    end
  end

  assign rd_data = mem[rptr][7:0];
  assign rd_ferr = mem[rptr][8];
  assign rd_perr = mem[rptr][9];

  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  a_r7_overrun_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(level) == LW'(DEPTH));
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !clr_flags |=> overrun);
  a_r9_break_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    break_det && !clr_flags |=> break_det);
  a_r8_break_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_det) |-> $past(st) == S_LOW);
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    level == '0 && !push |=> level == '0);
endmodule

// File: tb/async_rx_core_bench.sv
module async_rx_core_bench;
  localparam int BIT = 64;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic pop = 1'b0, clr_flags = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, overrun, break_det;
  logic [4:0] level;
  logic [1:0] dv;
  logic smp_tick;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) dv <= 2'd0;
    else        dv <= dv + 2'd1;
  end
  assign smp_tick = (dv == 2'd3);

  async_rx_core u_async_rx_core (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .rxd(rxd),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .pop(pop), .clr_flags(clr_flags),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .level(level), .overrun(overrun), .break_det(break_det)
  );

  // {stop2 low, len8, par_en, par_odd, stop2, data, flip parity, stop1 low, exp data, exp perr, exp ferr}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hD3, 1'b0, 1'b0, 8'h53, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h71, 1'b0, 1'b0, 8'h71, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic b, input int bits);
    rxd = b;
    repeat (bits * BIT) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic flip, input logic s1low, input logic s2low);
    logic [7:0] bits;
    logic p;
    bits = cfg_len8 ? d : {1'b0, d[6:0]};
    p = (^bits) ^ cfg_par_odd ^ flip;
    hold(1'b0, 1);
    for (int k = 0; k < (cfg_len8 ? 8 : 7); k++) hold(bits[k], 1);
    if (cfg_par_en) hold(p, 1);
    hold(!s1low, 1);
    if (cfg_stop2) hold(!s2low, 1);
    hold(1'b1, 2);
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clr();
    clr_flags = 1'b1;
    @(negedge clk);
    clr_flags = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [24:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 level", int'(level), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 break", int'(break_det), 0);
    hold(1'b1, 2);

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      cfg_len8 = v[23]; cfg_par_en = v[22]; cfg_par_odd = v[21]; cfg_stop2 = v[20];
      send(v[19:12], v[11], v[10], v[24]);
      chk("R6 level one", int'(level), 1);
      chk("R3 data", int'(rd_data), int'(v[9:2]));
      chk("R4 parity flag", int'(rd_perr), int'(v[1]));
      chk("R5 framing flag", int'(rd_ferr), int'(v[0]));
      do_pop();
      chk("R6 level after pop", int'(level), 0);
    end

    cfg_len8 = 1'b1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    hold(1'b1, 2);
    chk("R2 glitch ignored", int'(level), 0);
    send(8'h96, 1'b0, 1'b0, 1'b0);
    chk("R2 next char level", int'(level), 1);
    chk("R2 next char data", int'(rd_data), 8'h96);
    do_pop();

    do_pop();
    chk("R10 pop on empty", int'(level), 0);

    for (int i = 0; i < 17; i++) send(8'((i * 13 + 5) & 255), 1'b0, 1'b0, 1'b0);
    chk("R7 overrun set", int'(overrun), 1);
    chk("R6 level full", int'(level), 16);
    for (int i = 0; i < 16; i++) begin
      chk("R7 kept order", int'(rd_data), (i * 13 + 5) & 255);
      do_pop();
    end
    chk("R9 overrun held", int'(overrun), 1);
    do_clr();
    chk("R9 overrun cleared", int'(overrun), 0);

    hold(1'b0, 10);
    hold(1'b0, 3);
    hold(1'b1, 2);
    chk("R8 short low no break", int'(break_det), 0);
    chk("R5 ferr stored", int'(rd_ferr), 1);
    do_pop();

    hold(1'b0, 10);
    hold(1'b0, 12);
    chk("R8 break set", int'(break_det), 1);
    chk("R8 single entry", int'(level), 1);
    hold(1'b1, 2);
    chk("R9 break held", int'(break_det), 1);
    do_clr();
    chk("R9 break cleared", int'(break_det), 0);
    do_pop();
    chk("R8 queue drained", int'(level), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule